// File: doc/BRIEF.md
# SPI Master Controller with Register Interface

This block is an SPI bus master that software drives through a small 32-bit register window. Words written to the transmit data register are queued in a transmit FIFO. When the core is enabled, in master mode and not held off, it shifts the queued words out on MOSI one after another with no idle gap between them. At the same time it captures MISO, or its own MOSI in loopback, into a receive FIFO of the same depth. SCLK runs at a fixed fraction of the system clock, and each half period lasts `CLK_DIV` system cycles.

The usual sequence is as follows. Software sets the hold-off bit and loads the transmit FIFO. It writes the slave-select register and then clears the hold-off bit. It waits for the words to complete and then drains the receive FIFO. Clock polarity, clock phase, bit order and loopback are control-register bits. One register offset accepts a single key value that returns the whole core to its reset state.

Top module: `spim_ctrl`

## Requirements
- R1: After reset the control register (0x60) reads 0x100 (transmit hold-off bit 8 set), the status register (0x64) reads 0x5 (bit0 RX empty, bit2 TX empty), `ss_o` is all ones, SCLK is low and `rx_ovr_o` is low.
- R2: A write to 0x68 queues the low `DATA_W` bits in the transmit FIFO. Status bit3 (TX full) rises on the `FIFO_DEPTH`-th queued word. A write while the FIFO is full is dropped.
- R3: A word starts only when control bits 1 (enable) and 2 (master) are set and bit 8 (hold-off) is clear. While hold-off is set, queued words stay queued and SCLK does not toggle.
- R4: Each word takes exactly 2·`DATA_W`·`CLK_DIV` system cycles. The first word starts one cycle after hold-off is cleared, and the following words follow with no gap. Each received word enters the receive FIFO on the cycle its last SCLK edge is produced.
- R5: With control bit 0 set, MOSI is fed back to the receive shifter in place of MISO, so the received word equals the sent word. Bit 0 reads back as written.
- R6: SCLK idles at control bit 3 (CPOL). With control bit 4 (CPHA) clear, data is sampled on the first edge of each bit and changed on the second. With CPHA set, data is changed on the first edge and sampled on the second.
- R7: With control bit 9 set, words are sent and assembled least significant bit first. Otherwise they are sent most significant bit first.
- R8: Writing 1 to control bit 5 empties the transmit FIFO, and writing 1 to bit 6 empties the receive FIFO. Both bits always read 0.
- R9: Register 0x70 holds one bit per select line. With control bit 7 set, `ss_o` follows that register directly. With bit 7 clear, `ss_o` shows the register value only while a word is shifting and is all ones otherwise.
- R10: Writing 0x0000000A to 0x40 returns all registers, FIFOs and the shifter to the R1 state. Any other value written there has no effect.
- R11: A received word that arrives while the receive FIFO is full is dropped, the stored words are kept, and `rx_ovr_o` is high for exactly that one cycle.
- R12: A read from 0x6C pops one word, zero-extended to 32 bits. Status bit4 (mode fault) always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_en_i | input | 1 | Register access strobe, one cycle per access |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 8 | Byte offset of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from `reg_addr_i` |
| sclk_o | output | 1 | SPI serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_o | output | NUM_SS | Slave-select lines, active low |
| rx_ovr_o | output | 1 | One-cycle pulse when a received word is dropped |

## Verification
The main function is exercised by a table of single-word transfers covering all four CPOL/CPHA combinations, both bit orders and loopback. Each pattern is sent to a bench slave model that samples and drives by the clock-mode rules on its own, so a swapped sampling edge, a wrong idle level or a reversed bit order each show up as a different captured or returned word. Directed runs then fill the transmit FIFO to its depth under hold-off. They time the back-to-back burst to the exact cycle, force a receive overrun, and exercise the FIFO clear bits, the select-line modes and the soft-reset key against a wrong key.

// File: rtl/spim_pkg.sv
package spim_pkg;
  timeunit 1ns; timeprecision 100ps;

  localparam logic [7:0] ADDR_RST  = 8'h40;
  localparam logic [7:0] ADDR_CTRL = 8'h60;
  localparam logic [7:0] ADDR_STAT = 8'h64;
  localparam logic [7:0] ADDR_TXD  = 8'h68;
  localparam logic [7:0] ADDR_RXD  = 8'h6C;
  localparam logic [7:0] ADDR_SSEL = 8'h70;

  localparam logic [31:0] SOFT_RST_KEY = 32'h0000_000A;

  localparam int C_LOOP  = 0;
  localparam int C_EN    = 1;
  localparam int C_MST   = 2;
  localparam int C_CPOL  = 3;
  localparam int C_CPHA  = 4;
  localparam int C_TXCLR = 5;
  localparam int C_RXCLR = 6;
  localparam int C_MANSS = 7;
  localparam int C_INH   = 8;
  localparam int C_LSB   = 9;
  localparam int CTRL_W  = 10;

  localparam logic [CTRL_W-1:0] CTRL_RST   = 10'h100;
  localparam logic [CTRL_W-1:0] CTRL_WMASK = 10'h39F;  // clear bits never stored

  typedef struct packed {
    logic lsb;
    logic cpha;
    logic cpol;
    logic loop;
  } spim_mode_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o,
  output logic         drop_o
);
  timeunit 1ns; timeprecision 100ps;

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          acc, take;

  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CW'(DEPTH));
  assign acc     = push_i && !full_o;
  assign take    = pop_i && !empty_o;
  assign drop_o  = push_i && full_o;
  assign rdata_o = mem[rptr];

  always_ff @(posedge clk_i) begin
    if (acc) mem[wptr] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (clr_i) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (acc)  wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (take) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      cnt <= cnt + CW'(acc) - CW'(take);
    end
  end

  assert_drop_when_full_R2: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    push_i && full_o && !pop_i |=> full_o && $stable(cnt));

  assert_no_underflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/spim_shift.sv
module spim_shift
  import spim_pkg::*;
#(
  parameter int W       = 8,
  parameter int CLK_DIV = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         go_i,
  input  spim_mode_t   mode_i,
  input  logic [W-1:0] tx_word_i,
  output logic         tx_pop_o,
  output logic         rx_push_o,
  output logic [W-1:0] rx_word_o,
  output logic         busy_o,
  output logic         sclk_o,
  output logic         mosi_o,
  input  logic         miso_i
);
  timeunit 1ns; timeprecision 100ps;

  localparam int HW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int EW = $clog2(2 * W);
  localparam logic [HW-1:0] HLAST = HW'(CLK_DIV - 1);
  localparam logic [EW-1:0] ELAST = EW'(2 * W - 1);

  logic          busy_q, sclk_q;
  logic [HW-1:0] hcnt;
  logic [EW-1:0] ecnt;
  logic [W-1:0]  tx_sr, rx_sr, rx_nxt, tx_shf;
  logic          tick, last, lead, samp, chg, rx_bit, ld;

  assign tick = busy_q && (hcnt == HLAST);
  assign last = tick && (ecnt == ELAST);
  assign lead = ~ecnt[0];
  assign samp = tick && (lead != mode_i.cpha);
  // with CPHA set the first bit is already on MOSI before the first edge
  assign chg  = tick && (lead == mode_i.cpha) && !(mode_i.cpha && ecnt == '0);
  assign ld   = go_i && (!busy_q || last);

  assign mosi_o = mode_i.lsb ? tx_sr[0] : tx_sr[W-1];
  assign rx_bit = mode_i.loop ? mosi_o : miso_i;
  assign tx_shf = mode_i.lsb ? {1'b0, tx_sr[W-1:1]} : {tx_sr[W-2:0], 1'b0};

  always_comb begin
    rx_nxt = rx_sr;
    if (samp) rx_nxt = mode_i.lsb ? {rx_bit, rx_sr[W-1:1]} : {rx_sr[W-2:0], rx_bit};
  end

  assign tx_pop_o  = ld;
  assign rx_push_o = last;
  assign rx_word_o = rx_nxt;
  assign busy_o    = busy_q;
  assign sclk_o    = busy_q ? sclk_q : mode_i.cpol;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      hcnt   <= '0;
      ecnt   <= '0;
      tx_sr  <= '0;
      rx_sr  <= '0;
    end else if (clr_i) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      hcnt   <= '0;
      ecnt   <= '0;
      tx_sr  <= '0;
      rx_sr  <= '0;
    end else begin
      rx_sr <= rx_nxt;
      if (ld) begin
        busy_q <= 1'b1;
        tx_sr  <= tx_word_i;
        hcnt   <= '0;
        ecnt   <= '0;
        sclk_q <= mode_i.cpol;
      end else begin
        if (last)   busy_q <= 1'b0;
        if (busy_q) hcnt   <= tick ? '0 : hcnt + 1'b1;
        if (tick) begin
          sclk_q <= ~sclk_q;
          ecnt   <= ecnt + 1'b1;
        end
        if (chg) tx_sr <= tx_shf;
      end
    end
  end

  assert_hold_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    !go_i && !busy_q |=> !busy_q);

  assert_word_start_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !$past(busy_q) |-> sclk_o == $past(mode_i.cpol));
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int NUM_SS     = 4,
  parameter int CLK_DIV    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_en_i,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_SS-1:0] ss_o,
  output logic              rx_ovr_o
);
  timeunit 1ns; timeprecision 100ps;

  logic              wr, rd, soft_rst, ctrl_wr, ss_wr;
  logic              tx_clr, rx_clr, tx_push, rx_pop;
  logic [CTRL_W-1:0] ctrl_q;
  logic [NUM_SS-1:0] ss_q;
  logic [DATA_W-1:0] tx_word, rx_in, rx_word;
  logic              tx_empty, tx_full, tx_drop, tx_pop;
  logic              rx_empty, rx_full, rx_push;
  logic              busy, go;
  spim_mode_t        mode;

  assign wr       = reg_en_i && reg_we_i;
  assign rd       = reg_en_i && !reg_we_i;
  assign soft_rst = wr && (reg_addr_i == ADDR_RST) && (reg_wdata_i == SOFT_RST_KEY);
  assign ctrl_wr  = wr && (reg_addr_i == ADDR_CTRL);
  assign ss_wr    = wr && (reg_addr_i == ADDR_SSEL);
  assign tx_push  = wr && (reg_addr_i == ADDR_TXD);
  assign rx_pop   = rd && (reg_addr_i == ADDR_RXD) && !rx_empty;
  assign tx_clr   = soft_rst || (ctrl_wr && reg_wdata_i[C_TXCLR]);
  assign rx_clr   = soft_rst || (ctrl_wr && reg_wdata_i[C_RXCLR]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      ss_q   <= '1;
    end else if (soft_rst) begin
      ctrl_q <= CTRL_RST;
      ss_q   <= '1;
    end else begin
      if (ctrl_wr) ctrl_q <= reg_wdata_i[CTRL_W-1:0] & CTRL_WMASK;
      if (ss_wr)   ss_q   <= reg_wdata_i[NUM_SS-1:0];
    end
  end

  always_comb begin
    mode.lsb  = ctrl_q[C_LSB];
    mode.cpha = ctrl_q[C_CPHA];
    mode.cpol = ctrl_q[C_CPOL];
    mode.loop = ctrl_q[C_LOOP];
  end

  assign go = ctrl_q[C_EN] && ctrl_q[C_MST] && !ctrl_q[C_INH] && !tx_empty;

  spim_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk_i, .rst_ni, .clr_i(tx_clr),
    .push_i(tx_push), .wdata_i(reg_wdata_i[DATA_W-1:0]),
    .pop_i(tx_pop), .rdata_o(tx_word),
    .empty_o(tx_empty), .full_o(tx_full), .drop_o(tx_drop)
  );

  spim_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk_i, .rst_ni, .clr_i(rx_clr),
    .push_i(rx_push), .wdata_i(rx_in),
    .pop_i(rx_pop), .rdata_o(rx_word),
    .empty_o(rx_empty), .full_o(rx_full), .drop_o(rx_ovr_o)
  );

  spim_shift #(.W(DATA_W), .CLK_DIV(CLK_DIV)) u_shf (
    .clk_i, .rst_ni, .clr_i(soft_rst),
    .go_i(go), .mode_i(mode),
    .tx_word_i(tx_word), .tx_pop_o(tx_pop),
    .rx_push_o(rx_push), .rx_word_o(rx_in),
    .busy_o(busy), .sclk_o, .mosi_o, .miso_i
  );

  assign ss_o = (ctrl_q[C_MANSS] || busy) ? ss_q : '1;

  always_comb begin
    unique case (reg_addr_i)
      ADDR_CTRL: reg_rdata_o = 32'(ctrl_q);
      ADDR_STAT: reg_rdata_o = {27'b0, 1'b0, tx_full, tx_empty, rx_full, rx_empty};
      ADDR_RXD:  reg_rdata_o = 32'(rx_word);
      ADDR_SSEL: reg_rdata_o = 32'(ss_q);
      default:   reg_rdata_o = '0;
    endcase
  end

  assert_tx_drop_keeps_full_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_drop && !tx_pop && !tx_clr |=> tx_full);

  assert_manual_ss_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[C_MANSS] && ss_wr |=> ss_o == $past(reg_wdata_i[NUM_SS-1:0]));

  assert_soft_rst_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (ss_o == '1) && (reg_addr_i != ADDR_CTRL || reg_rdata_o == 32'(CTRL_RST)));

  assert_ovr_only_full_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ovr_o |-> rx_full);
endmodule

// File: tb/spim_ctrl_test.sv
module spim_ctrl_test;
  timeunit 1ns; timeprecision 100ps;

  localparam int W = 8;
  localparam int D = 4;
  localparam int WORD_CYC = 2 * W * 2;

  localparam logic [7:0] A_RST = 8'h40, A_CTRL = 8'h60, A_STAT = 8'h64;
  localparam logic [7:0] A_TXD = 8'h68, A_RXD = 8'h6C, A_SSEL = 8'h70;
  localparam logic [31:0] BASE = 32'h086;  // enable, master, manual select

  // {loop,lsb,cpha,cpol}, tx word, slave reply
  localparam logic [19:0] VEC [8] = '{
    20'h0A53C, 20'h15AC3, 20'h29669, 20'h30FF0,
    20'h48118, 20'h7C66C, 20'h8E700, 20'hE2D00
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_en = 1'b0, reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sclk_o, mosi_o, miso, rx_ovr_o;
  logic [3:0]  ss_o;

  int checks = 0;
  int errs = 0;
  int ovr_cnt = 0;

  logic       b_cpol = 1'b0, b_cpha = 1'b0, b_lsb = 1'b0;
  logic [7:0] slv_word = '0, slv_cap = '0, slv_got = '0;
  logic [2:0] sbit = '0;
  logic [2:0] spos;
  logic [3:0] vm;
  logic [7:0] vt, vs;
  logic [31:0] d, cw;

  always #2.5 clk = ~clk;

  spim_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_en_i(reg_en), .reg_we_i(reg_we),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso), .ss_o(ss_o), .rx_ovr_o(rx_ovr_o)
  );

  // bench slave on select line 0, following the clock-mode rules
  assign spos = b_lsb ? sbit : 3'd7 - sbit;
  assign miso = slv_word[spos];

  always @(sclk_o) begin
    if (ss_o[0] === 1'b0 && sclk_o !== 1'bx) begin
      if ((sclk_o != b_cpol) != b_cpha) begin
        slv_cap[spos] = mosi_o;
        if (sbit == 3'd7) slv_got = slv_cap;
        sbit = sbit + 3'd1;
      end
    end
  end

  always @(posedge ss_o[0]) sbit = 3'd0;

  always @(posedge clk) if (rx_ovr_o === 1'b1) ovr_cnt++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = v;
    @(posedge clk); #1;
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1 v = reg_rdata;
    @(posedge clk); #1;
    reg_en = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [31:0] v);
    reg_addr = a;
    #0.2 v = reg_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);

    // R1 reset state
    peek(A_CTRL, d); chk("R1 ctrl", d, 32'h100);
    peek(A_STAT, d); chk("R1 status", d, 32'h5);
    chk("R1 ss", 32'(ss_o), 32'hF);
    chk("R1 sclk", 32'(sclk_o), 32'h0);
    chk("R1 ovr", 32'(rx_ovr_o), 32'h0);

    // table walk: R5 R6 R7 modes against the bench slave
    for (int i = 0; i < 8; i++) begin
      vm = VEC[i][19:16]; vt = VEC[i][15:8]; vs = VEC[i][7:0];
      wr(A_SSEL, 32'hF);
      b_cpol = vm[0]; b_cpha = vm[1]; b_lsb = vm[2];
      slv_word = vs; slv_got = '0; sbit = '0;
      cw = BASE | (32'(vm[0]) << 3) | (32'(vm[1]) << 4) | (32'(vm[2]) << 9) | 32'(vm[3]);
      wr(A_CTRL, cw | 32'h100);
      chk($sformatf("R6 idle level vec%0d", i), 32'(sclk_o), 32'(vm[0]));
      wr(A_SSEL, 32'hE);
      wr(A_TXD, 32'(vt));
      wr(A_CTRL, cw);
      cyc(WORD_CYC + 8);
      rd(A_RXD, d);
      chk($sformatf("R5 R6 R7 rx word vec%0d", i), d, vm[3] ? 32'(vt) : 32'(vs));
      chk($sformatf("R6 R7 slave captured vec%0d", i), 32'(slv_got), 32'(vt));
      wr(A_SSEL, 32'hF);
    end

    // R2 R3 fill under hold-off, extra write dropped
    wr(A_CTRL, 32'h187);
    for (int k = 1; k <= D - 1; k++) wr(A_TXD, 32'(k));
    peek(A_STAT, d); chk("R2 not full at depth-1", d & 32'h8, 32'h0);
    wr(A_TXD, 32'(D));
    peek(A_STAT, d); chk("R2 full at depth", d & 32'h8, 32'h8);
    wr(A_TXD, 32'h99);
    cyc(50);
    peek(A_STAT, d); chk("R3 held: tx full, rx empty", d, 32'h9);
    chk("R3 sclk still", 32'(sclk_o), 32'h0);

    // R4 back-to-back burst timing
    wr(A_CTRL, 32'h087);
    cyc(D * WORD_CYC);
    peek(A_STAT, d); chk("R4 rx not yet full", d & 32'h2, 32'h0);
    cyc(1);
    peek(A_STAT, d); chk("R4 rx full on exact cycle", d & 32'h2, 32'h2);
    for (int k = 1; k <= D; k++) begin
      rd(A_RXD, d); chk($sformatf("R2 R4 word %0d", k), d, 32'(k));
    end
    peek(A_STAT, d); chk("R2 dropped word absent", d, 32'h5);

    // R11 overrun
    ovr_cnt = 0;
    wr(A_CTRL, 32'h187);
    for (int k = 0; k < D; k++) wr(A_TXD, 32'h11 + 32'(k));
    wr(A_CTRL, 32'h087);
    cyc(D * WORD_CYC + 10);
    chk("R11 no overrun while room", 32'(ovr_cnt), 32'h0);
    wr(A_TXD, 32'h55);
    cyc(WORD_CYC + 8);
    chk("R11 single overrun pulse", 32'(ovr_cnt), 32'h1);
    for (int k = 0; k < D; k++) begin
      rd(A_RXD, d); chk($sformatf("R11 kept word %0d", k), d, 32'h11 + 32'(k));
    end
    peek(A_STAT, d); chk("R11 new word dropped", d & 32'h1, 32'h1);

    // R8 FIFO clear bits
    wr(A_CTRL, 32'h187);
    wr(A_TXD, 32'h21); wr(A_TXD, 32'h22);
    peek(A_STAT, d); chk("R8 tx loaded", d & 32'h4, 32'h0);
    wr(A_CTRL, 32'h1A7);
    peek(A_STAT, d); chk("R8 tx cleared", d, 32'h5);
    peek(A_CTRL, d); chk("R8 clear bit reads 0", d, 32'h187);
    wr(A_CTRL, 32'h087);
    wr(A_TXD, 32'h77);
    cyc(WORD_CYC + 8);
    peek(A_STAT, d); chk("R8 rx loaded", d & 32'h1, 32'h0);
    wr(A_CTRL, 32'h0C7);
    peek(A_STAT, d); chk("R8 rx cleared", d & 32'h1, 32'h1);

    // R12 zero extension, mode fault
    wr(A_CTRL, 32'h087);
    wr(A_TXD, 32'h1A5);
    cyc(WORD_CYC + 8);
    rd(A_RXD, d); chk("R12 zero-extended", d, 32'hA5);
    peek(A_STAT, d); chk("R12 mode fault 0", d & 32'h10, 32'h0);

    // R9 select modes
    wr(A_CTRL, 32'h107);
    wr(A_SSEL, 32'hD);
    chk("R9 auto idle deselected", 32'(ss_o), 32'hF);
    peek(A_SSEL, d); chk("R9 register readback", d, 32'hD);
    wr(A_TXD, 32'h3);
    wr(A_CTRL, 32'h007);
    cyc(5);
    chk("R9 auto asserted while shifting", 32'(ss_o), 32'hD);
    cyc(WORD_CYC + 8);
    chk("R9 auto released after word", 32'(ss_o), 32'hF);
    rd(A_RXD, d);
    wr(A_CTRL, 32'h187);
    chk("R9 manual follows register", 32'(ss_o), 32'hD);

    // R10 soft reset key
    wr(A_RST, 32'h0B);
    peek(A_CTRL, d); chk("R10 wrong key ignored", d, 32'h187);
    wr(A_RST, 32'h0A);
    peek(A_CTRL, d); chk("R10 ctrl reset", d, 32'h100);
    peek(A_STAT, d); chk("R10 status reset", d, 32'h5);
    chk("R10 ss reset", 32'(ss_o), 32'hF);

    // R5 loopback readback
    wr(A_CTRL, 32'h001);
    peek(A_CTRL, d); chk("R5 loop bit readback", d, 32'h001);

    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule